// File: doc/BRIEF.md
# Interrupt-Capable Eight-Line GPIO Port

This block is one general-purpose I/O port of eight lines, reached through a flat register interface: writes land on the rising clock edge when the write strobe is high, and reads are combinational from the address. Each line has a stored output value and a direction bit. Pads are kept outside the block, which exposes an output-value vector and an output-enable vector for them, and takes the pad levels back in on its input vector.

Every line can act as an interrupt source. Two configuration bits per line pick level or edge sensing and the active polarity. Edge events are held in a per-line flag until software clears them by writing ones to a clear-on-write location. An enable bit gates each line. An optional per-line filter holds back a new input level until it has been seen on four consecutive slow sample ticks. Interrupt state is visible as a read-only status byte, on one output per line, and on a single output that is the OR of all lines.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `pinOe` and `pinOut` are 0, and `irqLine`/`irqAny` are low.
- R2: A write at 0x00 loads the whole output-value byte onto `pinOut`. A write at 0x10 loads the direction byte onto `pinOe`, where 1 means the line is driven.
- R3: A read at 0x00 returns, per bit, the stored value where direction is 1 and the input pin where direction is 0. The pin passes through two flops, so a change is readable after exactly two rising edges.
- R4: With sense bit (0x90) at 0, a line is level sensed. It is pending while enabled and the input equals its polarity bit (0x94), with 1 for high and 0 for low.
- R5: With sense bit 1, a line is edge sensed: a rising edge when polarity is 1, a falling edge when polarity is 0. The event is latched and stays pending after the input returns, and it is visible three edges after the pin change.
- R6: Writing 1s at 0x98 clears the latched edge flags of those lines, and 0 bits leave flags untouched. This location always reads 0.
- R7: If a new edge and a clear for the same line arrive on the same clock edge, the flag stays set.
- R8: A line whose enable bit (0x9C) is 0 shows no pending status and latches no edge, so enabling it later shows nothing from the disabled period.
- R9: With the filter bit (0xA8) set, the line's interrupt input only changes after the new level is seen on 4 consecutive sample ticks, one tick every DEB_DIV (default 4) clocks. A pulse of 6 clocks or shorter is ignored. The data read at 0x00 is never filtered.
- R10: The status byte at 0xA0 is read-only and reflects pending lines. `irqLine` equals it bit for bit, and `irqAny` is its OR.
- R11: The direction, sense, polarity, enable and filter registers read back what was written, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWr | input | 1 | Write strobe |
| regWdata | input | LINES | Write data |
| regRdata | output | LINES | Read data for `regAddr` |
| pinIn | input | LINES | Pad input levels |
| pinOut | output | LINES | Output values toward the pads |
| pinOe | output | LINES | Output enables toward the pads |
| irqAny | output | 1 | OR of all pending lines |
| irqLine | output | LINES | Pending state per line |

## Verification
The bench places a clear-on-write in the very cycle a new edge is latched. A design that lets the clear win there drops the interrupt. It toggles an edge-sensed line while the line is disabled and then enables it. A design that latches ungated edges raises a stale interrupt at that point. A six-clock pulse on a filtered line must never show up as pending, while a long level must get through. A filter with too short a window, or one that never accepts, fails one of those two checks. It also reads the data register one edge and two edges after a pin change to pin down the synchronizer depth. Writes to the status and clear locations must leave no readable trace.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register offsets; software depends on these positions.
  localparam logic [7:0] OFS_DATA     = 8'h00;
  localparam logic [7:0] OFS_DIR      = 8'h10;
  localparam logic [7:0] OFS_SENSE    = 8'h90;
  localparam logic [7:0] OFS_POLARITY = 8'h94;
  localparam logic [7:0] OFS_CLEAR    = 8'h98;
  localparam logic [7:0] OFS_ENABLE   = 8'h9C;
  localparam logic [7:0] OFS_STATUS   = 8'hA0;
  localparam logic [7:0] OFS_FILTER   = 8'hA8;

  // Write strobes from decode to the datapath.
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrSense;
    logic wrPolarity;
    logic wrClear;
    logic wrEnable;
    logic wrFilter;
  } regStrobes_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [LINES-1:0]  dataView,
  input  logic [LINES-1:0]  dirView,
  input  logic [LINES-1:0]  senseView,
  input  logic [LINES-1:0]  polarityView,
  input  logic [LINES-1:0]  enableView,
  input  logic [LINES-1:0]  filterView,
  input  logic [LINES-1:0]  statusView,
  output regStrobes_t       strb,
  output logic [LINES-1:0]  regRdata
);

  localparam logic [ADDR_W-1:0] A_DATA     = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DIR      = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_SENSE    = ADDR_W'(OFS_SENSE);
  localparam logic [ADDR_W-1:0] A_POLARITY = ADDR_W'(OFS_POLARITY);
  localparam logic [ADDR_W-1:0] A_CLEAR    = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_ENABLE   = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_FILTER   = ADDR_W'(OFS_FILTER);

  always_comb begin
    strb = '0;
    if (regWr) begin
      case (regAddr)
        A_DATA:     strb.wrData     = 1'b1;
        A_DIR:      strb.wrDir      = 1'b1;
        A_SENSE:    strb.wrSense    = 1'b1;
        A_POLARITY: strb.wrPolarity = 1'b1;
        A_CLEAR:    strb.wrClear    = 1'b1;
        A_ENABLE:   strb.wrEnable   = 1'b1;
        A_FILTER:   strb.wrFilter   = 1'b1;
        default:    strb = '0;  // status and unmapped: no effect
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      A_DATA:     regRdata = dataView;
      A_DIR:      regRdata = dirView;
      A_SENSE:    regRdata = senseView;
      A_POLARITY: regRdata = polarityView;
      A_ENABLE:   regRdata = enableView;
      A_STATUS:   regRdata = statusView;
      A_FILTER:   regRdata = filterView;
      default:    regRdata = '0;  // clear location is write-only
    endcase
  end

endmodule

// File: rtl/gpio_line_filter.sv
module gpio_line_filter #(
  parameter int unsigned DEB_COUNT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleStb,
  input  logic rawIn,
  input  logic bypass,
  output logic lineLvl
);

  localparam int unsigned CNT_W = (DEB_COUNT > 1) ? $clog2(DEB_COUNT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_COUNT - 1);

  logic             accepted;
  logic [CNT_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accepted <= 1'b0;
      runLen   <= '0;
    end else if (sampleStb) begin
      if (rawIn == accepted) begin
        runLen <= '0;
      end else if (runLen == CNT_LAST) begin
        accepted <= rawIn;
        runLen   <= '0;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  assign lineLvl = bypass ? rawIn : accepted;

  // R9
  filter_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> $stable(accepted));

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_DIV     = 4,
  parameter int unsigned DEB_COUNT   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strb,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] pinIn,
  output logic [LINES-1:0] pinOut,
  output logic [LINES-1:0] pinOe,
  output logic [LINES-1:0] dataView,
  output logic [LINES-1:0] senseView,
  output logic [LINES-1:0] polarityView,
  output logic [LINES-1:0] enableView,
  output logic [LINES-1:0] filterView,
  output logic [LINES-1:0] statusView
);

  localparam int unsigned DIV_W = (DEB_DIV > 1) ? $clog2(DEB_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DEB_DIV - 1);

  logic [LINES-1:0] dataReg, dirReg, senseReg, polarityReg, enableReg, filterReg;
  logic [LINES-1:0] edgeFlag, levPrev, lineLvl, pinSync;
  logic [LINES-1:0] riseHit, fallHit, edgeEvt, levelHit, clearMask;
  logic [SYNC_STAGES-1:0][LINES-1:0] syncPipe;
  logic [DIV_W-1:0] divCnt;
  logic             sampleStb;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg     <= '0;
      dirReg      <= '0;
      senseReg    <= '0;
      polarityReg <= '0;
      enableReg   <= '0;
      filterReg   <= '0;
    end else begin
      if (strb.wrData)     dataReg     <= wdata;
      if (strb.wrDir)      dirReg      <= wdata;
      if (strb.wrSense)    senseReg    <= wdata;
      if (strb.wrPolarity) polarityReg <= wdata;
      if (strb.wrEnable)   enableReg   <= wdata;
      if (strb.wrFilter)   filterReg   <= wdata;
    end
  end

  // Input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else begin
      syncPipe[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end
  assign pinSync = syncPipe[SYNC_STAGES-1];

  // Slow sample tick shared by all filters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end
  assign sampleStb = (divCnt == DIV_LAST);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    gpio_line_filter #(.DEB_COUNT(DEB_COUNT)) i_filter (
      .clk       (clk),
      .rstN      (rstN),
      .sampleStb (sampleStb),
      .rawIn     (pinSync[i]),
      .bypass    (!filterReg[i]),
      .lineLvl   (lineLvl[i])
    );
  end

  // Event detection
  assign riseHit   = lineLvl & ~levPrev;
  assign fallHit   = ~lineLvl & levPrev;
  assign edgeEvt   = enableReg & senseReg & ((polarityReg & riseHit) | (~polarityReg & fallHit));
  assign levelHit  = ~(lineLvl ^ polarityReg);
  assign clearMask = strb.wrClear ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levPrev  <= '0;
      edgeFlag <= '0;
    end else begin
      levPrev  <= lineLvl;
      edgeFlag <= (edgeFlag & ~clearMask) | edgeEvt;  // new edge beats clear
    end
  end

  assign statusView   = enableReg & ((senseReg & edgeFlag) | (~senseReg & levelHit));
  assign pinOut       = dataReg;
  assign pinOe        = dirReg;
  assign dataView     = (dirReg & dataReg) | (~dirReg & pinSync);
  assign senseView    = senseReg;
  assign polarityView = polarityReg;
  assign enableView   = enableReg;
  assign filterView   = filterReg;

  // R2
  data_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> (pinOut == $past(wdata)));

  // R6
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClear |=> ((edgeFlag & $past(wdata & ~edgeEvt)) == '0));

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeEvt != '0) |=> ((edgeFlag & $past(edgeEvt)) == $past(edgeEvt)));

  // R8
  gated_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((edgeFlag & ~$past(edgeFlag) & ~$past(enableReg & senseReg)) == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES       = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_DIV     = 4,
  parameter int unsigned DEB_COUNT   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [LINES-1:0]  regWdata,
  output logic [LINES-1:0]  regRdata,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  output logic              irqAny,
  output logic [LINES-1:0]  irqLine
);

  regStrobes_t      strb;
  logic [LINES-1:0] dataView, senseView, polarityView, enableView, filterView, statusView;

  gpio_irq_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) i_ctrl (
    .regAddr      (regAddr),
    .regWr        (regWr),
    .dataView     (dataView),
    .dirView      (pinOe),
    .senseView    (senseView),
    .polarityView (polarityView),
    .enableView   (enableView),
    .filterView   (filterView),
    .statusView   (statusView),
    .strb         (strb),
    .regRdata     (regRdata)
  );

  gpio_irq_datapath #(
    .LINES(LINES), .SYNC_STAGES(SYNC_STAGES), .DEB_DIV(DEB_DIV), .DEB_COUNT(DEB_COUNT)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wdata        (regWdata),
    .pinIn        (pinIn),
    .pinOut       (pinOut),
    .pinOe        (pinOe),
    .dataView     (dataView),
    .senseView    (senseView),
    .polarityView (polarityView),
    .enableView   (enableView),
    .filterView   (filterView),
    .statusView   (statusView)
  );

  assign irqLine = statusView;
  assign irqAny  = |statusView;

endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut, pinOe, irqLine;
  logic       irqAny;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqAny(irqAny), .irqLine(irqLine)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         kind;  // 0 rdata, 1 irqLine, 2 irqAny, 3 pinOut, 4 pinOe
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbQ[$];
  event  sampleEv;

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(sampleEv);
      #1;
      while (sbQ.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sbQ.pop_front();
        case (it.kind)
          0: act = regRdata;
          1: act = irqLine;
          2: act = {7'b0, irqAny};
          3: act = pinOut;
          default: act = pinOe;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    if (kind == 0) regAddr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    -> sampleEv;
    #2;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog all-reqs actual=running expected=done");
      summary();
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk(0, 8'h00, 8'h00, "R1 data");
    chk(0, 8'h10, 8'h00, "R1 dir");
    chk(0, 8'h9C, 8'h00, "R1 enable");
    chk(0, 8'hA0, 8'h00, "R1 status");
    chk(4, 0, 8'h00, "R1 pinOe");
    chk(3, 0, 8'h00, "R1 pinOut");
    chk(2, 0, 8'h00, "R1 irqAny");

    // R2 output drive
    wr(8'h00, 8'hA5);
    wr(8'h10, 8'h0F);
    chk(3, 0, 8'hA5, "R2 pinOut");
    chk(4, 0, 8'h0F, "R2 pinOe");
    // R3 mixed read and synchronizer depth
    pinIn = 8'h30; tick(3);
    chk(0, 8'h00, 8'h35, "R3 mixed read");
    pinIn = 8'hF0; tick(1);
    chk(0, 8'h00, 8'h35, "R3 one edge");
    tick(1);
    chk(0, 8'h00, 8'hF5, "R3 two edges");
    wr(8'h10, 8'h00); wr(8'h00, 8'h00); pinIn = 8'h00; tick(3);

    // R11 readback and unmapped
    wr(8'h90, 8'h5A); chk(0, 8'h90, 8'h5A, "R11 sense");
    wr(8'h94, 8'hC3); chk(0, 8'h94, 8'hC3, "R11 polarity");
    wr(8'hA8, 8'h81); chk(0, 8'hA8, 8'h81, "R11 filter");
    wr(8'h9C, 8'h00); chk(0, 8'h04, 8'h00, "R11 unmapped");
    wr(8'h90, 8'h00); wr(8'h94, 8'h00); wr(8'hA8, 8'h00);
    // R10 status read-only
    wr(8'hA0, 8'hFF); chk(0, 8'hA0, 8'h00, "R10 status ro");

    // R4 level high on line 0, level low on line 4
    wr(8'h94, 8'h01); wr(8'h9C, 8'h01);
    chk(1, 0, 8'h00, "R4 high idle");
    pinIn = 8'h01; tick(3);
    chk(1, 0, 8'h01, "R4 high active");
    chk(2, 0, 8'h01, "R10 irqAny");
    chk(0, 8'hA0, 8'h01, "R10 status");
    pinIn = 8'h00; tick(3);
    chk(1, 0, 8'h00, "R4 high released");
    wr(8'h9C, 8'h10);
    chk(1, 0, 8'h10, "R4 low active");
    pinIn = 8'h10; tick(3);
    chk(1, 0, 8'h00, "R4 low released");
    pinIn = 8'h00; wr(8'h9C, 8'h00); tick(3);

    // R5 rising edge on line 2
    wr(8'h90, 8'h04); wr(8'h94, 8'h04); wr(8'h9C, 8'h04);
    pinIn = 8'h04; tick(2);
    chk(1, 0, 8'h00, "R5 not yet");
    tick(1);
    chk(1, 0, 8'h04, "R5 rise latched");
    pinIn = 8'h00; tick(3);
    chk(1, 0, 8'h04, "R5 held");
    // R6 clear behaviour
    wr(8'h98, 8'h00); chk(1, 0, 8'h04, "R6 zero write");
    chk(0, 8'h98, 8'h00, "R6 reads zero");
    wr(8'h98, 8'h04); chk(1, 0, 8'h00, "R6 cleared");
    // R5 falling edge on line 3
    wr(8'h90, 8'h0C); wr(8'h9C, 8'h0C);
    pinIn = 8'h08; tick(3);
    chk(1, 0, 8'h00, "R5 rise ignored");
    pinIn = 8'h00; tick(3);
    chk(1, 0, 8'h08, "R5 fall latched");
    wr(8'h98, 8'h08); chk(1, 0, 8'h00, "R6 fall cleared");

    // R7 edge and clear on the same edge
    pinIn = 8'h04; tick(2);
    wr(8'h98, 8'h04);
    chk(1, 0, 8'h04, "R7 edge wins");
    wr(8'h98, 8'h04); chk(1, 0, 8'h00, "R7 later clear");
    pinIn = 8'h00; tick(3);

    // R8 disabled line latches nothing
    wr(8'h9C, 8'h00);
    pinIn = 8'h04; tick(3);
    chk(2, 0, 8'h00, "R8 disabled");
    pinIn = 8'h00; tick(3);
    wr(8'h9C, 8'h04);
    chk(1, 0, 8'h00, "R8 no stale edge");
    wr(8'h9C, 8'h00); wr(8'h90, 8'h00);

    // R9 filter on line 1, level high
    wr(8'h94, 8'h02); wr(8'hA8, 8'h02); wr(8'h9C, 8'h02);
    pinIn = 8'h02; tick(2);
    chk(0, 8'h00, 8'h02, "R9 data unfiltered");
    tick(4); pinIn = 8'h00;
    for (int k = 0; k < 12; k++) begin
      chk(1, 0, 8'h00, "R9 glitch ignored");
      tick(1);
    end
    pinIn = 8'h02; tick(24);
    chk(1, 0, 8'h02, "R9 accepted");
    pinIn = 8'h00; tick(24);
    chk(1, 0, 8'h00, "R9 released");

    tick(2);
    finished = 1;
    summary();
  end
endmodule